// File: doc/BRIEF.md
# Merged Status Interrupt Controller

This block folds three status events into one registered interrupt bit: a change of the link-good level, a statistics counter rollover, and a transmit error. Each event has its own enable bit in a CPU-writable control register. An event reaches the interrupt output only while its enable bit is set. The enable bits are also driven out so that software can read them back.

The link-good input is asynchronous. It passes through a synchroniser, and both its rising and its falling transitions are latched. A transmit error is not a separate input. The block infers it when the transmit-enable bit drops while the transmit-success bit is low. The rollover flag is a level held by the counter logic outside this block, so it is gated but not latched here.

Latched link and transmit-error events stay pending while their enable is clear, so turning an enable on later exposes an event that is already pending. Any write to the control byte that holds the link enable acknowledges a pending link change. The transmit-error latch clears when transmission is enabled again.

Top module: `evt_irq_merge`

## Requirements
- R1: After reset all three enable outputs are 0 and `irq_o` is 0.
- R2: A write with `wr_en_i` high, `wr_addr_i` equal to `CTRL_ADDR` (default 0xC) and the strobe for byte 0 set loads the enables from `wr_data_i`: link enable from bit 7, rollover enable from bit 6, transmit-error enable from bit 5. The enable outputs change one clock later. A write to any other address, or one with the byte-0 strobe clear, leaves the enables unchanged.
- R3: A rising or a falling transition of `link_ok_i` latches a link-change event. With the link enable set, `irq_o` goes high on the fourth clock edge after the input changes: two edges of synchroniser, one of edge detection and one of output register.
- R4: `irq_o` equals (`roll_flag_i` AND rollover enable) as sampled at the previous clock edge.
- R5: A clock edge that sees `tx_en_i` low after it was high on the previous edge, with `tx_ok_i` low, latches a transmit-error event. With the transmit-error enable set, `irq_o` rises on the next edge. The same fall with `tx_ok_i` high latches nothing.
- R6: A rise of `tx_en_i` clears a latched transmit-error event, and `irq_o` drops one edge later.
- R7: Any accepted byte-0 write to the control register clears the latched link-change event, whatever value it writes. A new edge in the same cycle wins over the clear. A write that is not accepted clears nothing.
- R8: Events latch while their enable is clear and do not raise `irq_o`. Setting the enable later raises `irq_o` one edge after the enable output rises.
- R9: A `link_ok_i` level that is held steady through reset latches no link-change event once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_ok_i | input | 1 | Asynchronous link-good level |
| roll_flag_i | input | 1 | Counter rollover flag (level) |
| tx_en_i | input | 1 | Transmit-enable bit |
| tx_ok_i | input | 1 | Transmit-success bit |
| wr_en_i | input | 1 | CPU write strobe |
| wr_addr_i | input | ADDR_W | CPU write address |
| wr_data_i | input | DATA_W | CPU write data |
| wr_strb_i | input | DATA_W/8 | Byte write strobes |
| link_en_o | output | 1 | Link-change enable readback |
| roll_en_o | output | 1 | Rollover enable readback |
| txerr_en_o | output | 1 | Transmit-error enable readback |
| irq_o | output | 1 | Registered merged interrupt |

## Verification
The bench uses the default parameters: two synchroniser stages, a 16-bit write bus with two byte strobes, and the control register at address 0xC. With two strobes, a write that touches only the upper byte is possible, so the bench can show that such a write neither changes the enables nor acknowledges a link event. With two synchroniser stages, the exact four-edge link latency and the three-cycle arming window after reset can both be checked at fixed sample points.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  typedef enum logic [1:0] {
    SRC_LINK  = 2'd0,
    SRC_ROLL  = 2'd1,
    SRC_TXERR = 2'd2
  } evt_src_e;

  localparam int NUM_SRC = 3;
endpackage

// File: rtl/link_edge_sync.sv
module link_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic change_o
);
  localparam int ARM  = STAGES + 1;
  localparam int CW   = $clog2(ARM + 1);
  localparam logic [CW-1:0] ARM_V = CW'(ARM);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic [CW-1:0]     arm_cnt_q;
  logic              armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      prev_q    <= 1'b0;
      arm_cnt_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], level_i};
      prev_q <= sync_q[STAGES-1];
      if (arm_cnt_q != ARM_V) arm_cnt_q <= arm_cnt_q + 1'b1;
    end
  end

  assign armed    = (arm_cnt_q == ARM_V);
  assign change_o = armed && (sync_q[STAGES-1] ^ prev_q);
endmodule

// File: rtl/tx_err_detect.sv
module tx_err_detect (
  input  logic clk,
  input  logic rst,
  input  logic tx_en_i,
  input  logic tx_ok_i,
  output logic err_set_o,
  output logic restart_o
);
  logic tx_en_q;

  always_ff @(posedge clk) begin
    if (rst) tx_en_q <= 1'b0;
    else     tx_en_q <= tx_en_i;
  end

  assign err_set_o = tx_en_q && !tx_en_i && !tx_ok_i;
  assign restart_o = !tx_en_q && tx_en_i;
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  // R7
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hC,
  parameter int LINK_EN_BIT  = 7,
  parameter int ROLL_EN_BIT  = 6,
  parameter int TXERR_EN_BIT = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [DATA_W/8-1:0]           wr_strb_i,
  output logic [evt_irq_pkg::NUM_SRC-1:0] en_o,
  output logic                          link_ack_o
);
  import evt_irq_pkg::*;

  localparam int STRB_W = DATA_W / 8;
  localparam int POS [NUM_SRC] = '{LINK_EN_BIT, ROLL_EN_BIT, TXERR_EN_BIT};

  logic               hit;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] bit_wr;

  assign hit = wr_en_i && (wr_addr_i == CTRL_ADDR);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_en
    assign bit_wr[k] = hit && wr_strb_i[POS[k] / 8];
    always_ff @(posedge clk) begin
      if (rst)            en_q[k] <= 1'b0;
      else if (bit_wr[k]) en_q[k] <= wr_data_i[POS[k]];
    end
  end

  logic unused_bus;
  assign unused_bus = ^{wr_data_i, wr_strb_i, STRB_W[0]};

  assign en_o       = en_q;
  assign link_ack_o = bit_wr[SRC_LINK];

  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i || wr_addr_i != CTRL_ADDR) |=> $stable(en_o));
endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge #(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hC,
  parameter int LINK_EN_BIT  = 7,
  parameter int ROLL_EN_BIT  = 6,
  parameter int TXERR_EN_BIT = 5,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                link_ok_i,
  input  logic                roll_flag_i,
  input  logic                tx_en_i,
  input  logic                tx_ok_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [DATA_W/8-1:0] wr_strb_i,
  output logic                link_en_o,
  output logic                roll_en_o,
  output logic                txerr_en_o,
  output logic                irq_o
);
  import evt_irq_pkg::*;

  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] gated;
  logic link_ack, link_chg, tx_set, tx_restart;
  logic irq_q;

  irq_ctrl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .LINK_EN_BIT(LINK_EN_BIT), .ROLL_EN_BIT(ROLL_EN_BIT),
    .TXERR_EN_BIT(TXERR_EN_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .wr_strb_i(wr_strb_i),
    .en_o(en), .link_ack_o(link_ack)
  );

  link_edge_sync #(.STAGES(SYNC_STAGES)) u_link (
    .clk(clk), .rst(rst), .level_i(link_ok_i), .change_o(link_chg)
  );

  sticky_flag u_link_pend (
    .clk(clk), .rst(rst), .set_i(link_chg), .clr_i(link_ack),
    .flag_o(pend[SRC_LINK])
  );

  tx_err_detect u_txdet (
    .clk(clk), .rst(rst), .tx_en_i(tx_en_i), .tx_ok_i(tx_ok_i),
    .err_set_o(tx_set), .restart_o(tx_restart)
  );

  sticky_flag u_tx_pend (
    .clk(clk), .rst(rst), .set_i(tx_set), .clr_i(tx_restart),
    .flag_o(pend[SRC_TXERR])
  );

  assign pend[SRC_ROLL] = roll_flag_i;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_gate
    assign gated[k] = pend[k] & en[k];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |gated;
  end

  assign irq_o      = irq_q;
  assign link_en_o  = en[SRC_LINK];
  assign roll_en_o  = en[SRC_ROLL];
  assign txerr_en_o = en[SRC_TXERR];

  // R4
  roll_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (roll_flag_i && roll_en_o) |=> irq_o);
  // R8
  pend_exposed_chk: assert property (@(posedge clk) disable iff (rst)
    (pend[SRC_LINK] && link_en_o) |=> irq_o);
  // R5
  tx_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tx_en_i) && !tx_en_i && !tx_ok_i) |=> pend[SRC_TXERR]);
  // R5
  tx_good_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(tx_en_i) && !tx_en_i && tx_ok_i && !pend[SRC_TXERR]) |=> !pend[SRC_TXERR]);
  // R8
  all_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!link_en_o && !roll_en_o && !txerr_en_o) |=> !irq_o);
endmodule

// File: tb/evt_irq_merge_bench.sv
module evt_irq_merge_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_ok = 1'b0, roll_flag = 1'b0, tx_en = 1'b0, tx_ok = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0] wr_strb = '0;
  logic link_en, roll_en, txerr_en, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_irq_merge u_evt_irq_merge (
    .clk(clk), .rst(rst), .link_ok_i(link_ok), .roll_flag_i(roll_flag),
    .tx_en_i(tx_en), .tx_ok_i(tx_ok), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_strb_i(wr_strb), .link_en_o(link_en),
    .roll_en_o(roll_en), .txerr_en_o(txerr_en), .irq_o(irq)
  );

  // {roll enable, roll flag, expected irq}
  localparam logic [2:0] VEC [6] = '{3'b000, 3'b010, 3'b100, 3'b111, 3'b010, 3'b111};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] s);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
    tick(1);
    wr_en = 1'b0; wr_strb = '0;
  endtask

  function automatic logic [15:0] ens(input logic l, input logic r, input logic t);
    return {8'h00, l, r, t, 5'b0};
  endfunction

  task automatic do_reset();
    rst = 1'b1; tick(3); rst = 1'b0; tick(1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    tick(1);
    do_reset();
    // R1 reset state
    check("R1 link_en", link_en, 1'b0);
    check("R1 roll_en", roll_en, 1'b0);
    check("R1 txerr_en", txerr_en, 1'b0);
    check("R1 irq", irq, 1'b0);

    // R4 table of rollover gating vectors
    for (int i = 0; i < 6; i++) begin
      wr(4'hC, ens(1'b0, VEC[i][2], 1'b0), 2'b01);
      roll_flag = VEC[i][1];
      tick(1);
      check("R4 roll gate", irq, VEC[i][0]);
      check("R2 roll_en load", roll_en, VEC[i][2]);
    end
    roll_flag = 1'b0;
    wr(4'hC, ens(1'b0, 1'b0, 1'b0), 2'b01);

    // R2 writes that must be ignored
    wr(4'h3, 16'hFFFF, 2'b11);
    tick(1);
    check("R2 wrong addr", link_en, 1'b0);
    wr(4'hC, 16'hFFFF, 2'b10);
    tick(1);
    check("R2 strobe off", roll_en, 1'b0);

    // R3 link rise with enable set, exact latency
    wr(4'hC, ens(1'b1, 1'b0, 1'b0), 2'b01);
    tick(1);
    link_ok = 1'b1;
    tick(3);
    check("R3 rise not yet", irq, 1'b0);
    tick(1);
    check("R3 rise latency", irq, 1'b1);

    // R7 ack by any byte-0 write, even writing the same value
    wr(4'hC, ens(1'b1, 1'b0, 1'b0), 2'b01);
    tick(1);
    check("R7 ack clears", irq, 1'b0);

    // R3 falling transition
    link_ok = 1'b0;
    tick(4);
    check("R3 fall", irq, 1'b1);

    // R7 ignored writes do not acknowledge
    wr(4'hC, 16'h0000, 2'b10);
    tick(1);
    check("R7 upper strobe no ack", irq, 1'b1);
    wr(4'h2, 16'h0000, 2'b01);
    tick(1);
    check("R7 other addr no ack", irq, 1'b1);
    wr(4'hC, ens(1'b0, 1'b0, 1'b0), 2'b01);
    tick(1);
    check("R7 ack with zero", irq, 1'b0);

    // R8 accumulate while disabled, then expose
    link_ok = 1'b1;
    tick(6);
    check("R8 disabled quiet", irq, 1'b0);
    wr(4'hC, ens(1'b0, 1'b0, 1'b1), 2'b01);
    tx_en = 1'b1; tx_ok = 1'b0;
    tick(2);
    tx_en = 1'b0;
    tick(2);
    check("R5 tx error irq", irq, 1'b1);

    // R6 restart clears transmit error
    tx_en = 1'b1;
    tick(2);
    check("R6 restart clears", irq, 1'b0);

    // R5 successful completion latches nothing
    tx_ok = 1'b1;
    tick(1);
    tx_en = 1'b0;
    tick(3);
    check("R5 success quiet", irq, 1'b0);

    // R8 transmit error latched while disabled, exposed on enable
    wr(4'hC, ens(1'b0, 1'b0, 1'b0), 2'b01);
    tx_ok = 1'b0; tx_en = 1'b1;
    tick(2);
    tx_en = 1'b0;
    tick(3);
    check("R8 tx pending hidden", irq, 1'b0);
    wr(4'hC, ens(1'b0, 1'b0, 1'b1), 2'b01);
    check("R8 enable visible", txerr_en, 1'b1);
    tick(1);
    check("R8 tx pending exposed", irq, 1'b1);

    // R9 link level held high through reset yields no event
    link_ok = 1'b1;
    do_reset();
    wr(4'hC, ens(1'b1, 1'b0, 1'b0), 2'b01);
    tick(6);
    check("R9 no event after reset", irq, 1'b0);

    done = 1;
    summary();
  end
endmodule